// File: doc/BRIEF.md
# Gated Phase Frequency Detector

This block compares the rising edges of a divided reference and a divided feedback signal. It drives a pair of pump requests. The `up` output rises when the reference edge leads, and `dn` rises when the feedback edge leads. The leading request stays high alone for as long as the lagging edge is late. After the lagging edge arrives, both requests stay high together for a short overlap whose length is set in clock cycles by `dly_sel`. Both then clear, so every comparison gives a small overlap pulse and the transfer function has no dead zone. Both edge inputs pass through a two-flop synchronizer and a rising-edge detector that run on the system clock.

A chip-enable input gates the block. While `chip_en` is low, both requests are held low, the three-state enable for the external pump (`pump_oe`) drops, and the lock detector is cleared. When `chip_en` returns high, both request flops start cleared. The next new rising edge on either input starts a fresh comparison. An input that is already high does not count as an edge.

A digital lock detector judges every completed comparison. A comparison is good when the time during which exactly one request was high is no more than 2 clock cycles. After 16 good comparisons in a row, `locked` goes high. A single comparison that is too wide clears the run and drops `locked`.

Top module: `pfd_gated`

## Requirements
- R1: A rising edge of `ref_in` that is first seen by the clock at edge k makes `up` high after clock edge k+2.
- R2: A rising edge of `fb_in` that is first seen by the clock at edge k makes `dn` high after clock edge k+2.
- R3: When both requests are high, they stay high together for exactly `dly_sel`+1 clock cycles (dly_sel 0..3 gives 1..4 cycles). Both then fall on the same edge.
- R4: The leading request is high alone for as many cycles as its input edge leads the other input edge. The lagging request is never high alone.
- R5: `chip_en` low forces `up` and `dn` low at the next clock edge. `pump_oe` is `chip_en` delayed by one clock cycle.
- R6: `chip_en` low clears `locked` at the next clock edge and clears the count of good comparisons.
- R7: After `chip_en` returns high, an input that stayed high through the disable period starts nothing. The first new rising edge on either input starts a comparison.
- R8: `locked` (active high) rises only after 16 consecutive completed comparisons, each with at most 2 cycles of single-request time.
- R9: A completed comparison with more than 2 cycles of single-request time drops `locked` and restarts the count of good comparisons.
- R10: During reset and just after it, `up`, `dn`, `locked` and `pump_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Divided reference signal (asynchronous) |
| fb_in | input | 1 | Divided feedback signal (asynchronous) |
| dly_sel | input | 2 | Overlap length minus one, in clock cycles |
| chip_en | input | 1 | Active-high enable; low idles the pump and clears lock |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| pump_oe | output | 1 | Output enable for the three-state pump |
| locked | output | 1 | Digital lock indication, active high |

## Verification
An input change driven on a falling clock edge first shows on `up` or `dn` at the third falling edge after it. The synchronizer, the edge detector and the request flop add one cycle each. The bench starts a per-cycle sample loop at the drive point, so it can expect the first request at loop index 2 and count single-request and overlap cycles across a fixed 16-cycle window. `pump_oe`, the chip-enable clearing and `locked` take effect one cycle after the deciding edge. The bench reads them at the next falling edge, or after the comparison has fully drained.

// File: rtl/pfd_gated_pkg.sv
package pfd_gated_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_pair_t;

    localparam pfd_pair_t PAIR_IDLE = '{up: 1'b0, dn: 1'b0};

    function automatic logic pair_both(input pfd_pair_t p);
        return p.up & p.dn;
    endfunction

    function automatic logic pair_single(input pfd_pair_t p);
        return p.up ^ p.dn;
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], sig_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pfd_gated_core.sv
module pfd_gated_core
    import pfd_gated_pkg::*;
#(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             chip_en,
    output pfd_pair_t        pair,
    output logic             cmp_done
);
    pfd_pair_t        q, q_nxt;
    logic [DLY_W-1:0] cnt, cnt_nxt;

    always_comb begin
        q_nxt    = q;
        cnt_nxt  = cnt;
        cmp_done = pair_both(q) && (cnt == dly_sel);
        if (pair_both(q)) begin
            if (cmp_done) begin
                q_nxt   = PAIR_IDLE;
                cnt_nxt = '0;
            end else begin
                cnt_nxt = cnt + 1'b1;
            end
        end
        if (ref_rise) q_nxt.up = 1'b1;
        if (fb_rise)  q_nxt.dn = 1'b1;
        if (!chip_en) begin
            q_nxt   = PAIR_IDLE;
            cnt_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= PAIR_IDLE;
            cnt <= '0;
        end else begin
            q   <= q_nxt;
            cnt <= cnt_nxt;
        end
    end

    assign pair = q;
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det
    import pfd_gated_pkg::*;
#(
    parameter int LOCK_CNT = 16,
    parameter int ERR_TOL  = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      chip_en,
    input  pfd_pair_t pair,
    input  logic      cmp_done,
    output logic      locked
);
    localparam int GW = $clog2(LOCK_CNT + 1);
    localparam int EW = $clog2(ERR_TOL + 2);
    localparam logic [EW-1:0] ERR_SAT = EW'(ERR_TOL + 1);
    localparam logic [EW-1:0] ERR_MAX = EW'(ERR_TOL);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_CNT - 1);
    localparam logic [GW-1:0] GOOD_SAT  = GW'(LOCK_CNT);

    logic [EW-1:0] err_cnt;
    logic [GW-1:0] good_cnt;
    logic          good;

    assign good = (err_cnt <= ERR_MAX);

    always_ff @(posedge clk) begin
        if (rst || !chip_en) begin
            err_cnt  <= '0;
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (cmp_done) begin
            err_cnt <= '0;
            if (good) begin
                if (good_cnt == GOOD_LAST) locked <= 1'b1;
                if (good_cnt != GOOD_SAT)  good_cnt <= good_cnt + 1'b1;
            end else begin
                good_cnt <= '0;
                locked   <= 1'b0;
            end
        end else if (pair_single(pair) && err_cnt != ERR_SAT) begin
            err_cnt <= err_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfd_gated.sv
module pfd_gated
    import pfd_gated_pkg::*;
#(
    parameter int DLY_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CNT    = 16,
    parameter int ERR_TOL     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             chip_en,
    output logic             up,
    output logic             dn,
    output logic             pump_oe,
    output logic             locked
);
    logic      ref_rise, fb_rise, cmp_done;
    pfd_pair_t pair;

    pfd_edge_det #(.STAGES(SYNC_STAGES)) u_ref_edge (
        .clk(clk), .rst(rst), .sig_in(ref_in), .rise(ref_rise));

    pfd_edge_det #(.STAGES(SYNC_STAGES)) u_fb_edge (
        .clk(clk), .rst(rst), .sig_in(fb_in), .rise(fb_rise));

    pfd_gated_core #(.DLY_W(DLY_W)) u_core (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .dly_sel(dly_sel), .chip_en(chip_en), .pair(pair),
        .cmp_done(cmp_done));

    pfd_lock_det #(.LOCK_CNT(LOCK_CNT), .ERR_TOL(ERR_TOL)) u_lock (
        .clk(clk), .rst(rst), .chip_en(chip_en), .pair(pair),
        .cmp_done(cmp_done), .locked(locked));

    always_ff @(posedge clk) begin
        if (rst) pump_oe <= 1'b0;
        else     pump_oe <= chip_en;
    end

    assign up = pair.up;
    assign dn = pair.dn;
endmodule

// File: rtl/pfd_gated_chk.sv
module pfd_gated_chk #(
    parameter int DLY_W = 2
) (
    input logic clk,
    input logic rst,
    input logic chip_en,
    input logic up,
    input logic dn,
    input logic pump_oe,
    input logic locked
);
    logic [DLY_W+1:0] ov_cnt;

    always_ff @(posedge clk) begin
        if (rst || !(up && dn)) ov_cnt <= '0;
        else if (ov_cnt != '1)  ov_cnt <= ov_cnt + 1'b1;
    end

    // R3: overlap never lasts longer than the largest setting
    p_overlap_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ov_cnt <= (DLY_W+2)'(2 ** DLY_W));

    // R5: disable idles both requests on the next edge
    p_ce_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> (!up && !dn));

    // R5: pump enable follows chip enable by one cycle
    p_oe_follow_r5: assert property (@(posedge clk) disable iff (rst)
        chip_en |=> pump_oe);

    // R5: no request while the pump is three-stated
    p_oe_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !pump_oe |-> (!up && !dn));

    // R6: disable clears lock
    p_ce_unlock_r6: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !locked);

    // R8: lock is only gained at the end of an overlap
    p_lock_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(up && dn));
endmodule

bind pfd_gated pfd_gated_chk #(.DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst(rst), .chip_en(chip_en), .up(up), .dn(dn),
    .pump_oe(pump_oe), .locked(locked));

// File: tb/pfd_gated_tb.sv
module pfd_gated_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic       chip_en = 1'b1;
    logic       up, dn, pump_oe, locked;

    int checks = 0;
    int failures = 0;
    int good_run = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfd_gated dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .dly_sel(dly_sel), .chip_en(chip_en), .up(up), .dn(dn),
        .pump_oe(pump_oe), .locked(locked));

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // off >= 0: reference leads by off cycles; off < 0: feedback leads
    task automatic run_cmp(input int off, input int dly);
        int lag = (off < 0) ? -off : off;
        int n_up = 0, n_dn = 0, n_both = 0, first = -1;
        dly_sel = 2'(dly);
        for (int i = 0; i < 16; i++) begin
            if (i == 0) begin
                if (off >= 0) ref_in = 1'b1; else fb_in = 1'b1;
            end
            if (i == lag) begin
                ref_in = 1'b1;
                fb_in  = 1'b1;
            end
            @(negedge clk);
            if (up && !dn) n_up++;
            if (dn && !up) n_dn++;
            if (up && dn)  n_both++;
            if (first < 0 && ((off >= 0) ? up : dn)) first = i;
        end
        if (off >= 0) begin
            check("R1", "first up index", first, 2);
            check("R4", "up-only cycles", n_up, lag);
            check("R4", "dn-only cycles", n_dn, 0);
        end else begin
            check("R2", "first dn index", first, 2);
            check("R4", "dn-only cycles", n_dn, lag);
            check("R4", "up-only cycles", n_up, 0);
        end
        check("R3", "overlap cycles", n_both, dly + 1);
        check("R3", "idle after overlap", int'(up | dn), 0);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (5) @(negedge clk);
        if (lag <= 2) good_run++; else good_run = 0;
        check((lag <= 2) ? "R8" : "R9", "locked", int'(locked),
              int'(good_run >= 16));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R10", "up in reset", int'(up), 0);
        check("R10", "dn in reset", int'(dn), 0);
        check("R10", "locked in reset", int'(locked), 0);
        check("R10", "pump_oe in reset", int'(pump_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5", "pump_oe after reset", int'(pump_oe), 1);
        check("R10", "locked after reset", int'(locked), 0);

        // R8: build lock with small errors, R9: lose it with a wide one
        for (int k = 0; k < 16; k++) run_cmp((k % 2) ? 1 : -2, k % 4);
        run_cmp(3, 1);
        for (int k = 0; k < 16; k++) run_cmp(k % 3, 0);

        // R5/R6: disable mid-pulse
        ref_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R5", "up before disable", int'(up), 1);
        chip_en = 1'b0;
        @(negedge clk);
        check("R5", "up after disable", int'(up), 0);
        check("R5", "dn after disable", int'(dn), 0);
        check("R5", "pump_oe after disable", int'(pump_oe), 0);
        check("R6", "locked after disable", int'(locked), 0);
        good_run = 0;
        repeat (3) @(negedge clk);

        // R7: held level is no edge after re-enable
        chip_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R7", "up with held ref", int'(up), 0);
            check("R7", "dn with held ref", int'(dn), 0);
        end
        check("R5", "pump_oe after enable", int'(pump_oe), 1);
        fb_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", "dn on fresh edge", int'(dn), 1);
        check("R7", "up on fresh edge", int'(up), 0);
        ref_in = 1'b0;
        repeat (3) @(negedge clk);
        ref_in = 1'b1;
        repeat (10) @(negedge clk);
        check("R3", "idle after re-enable compare", int'(up | dn), 0);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (5) @(negedge clk);
        good_run = 0;
        check("R9", "locked after wide compare", int'(locked), 0);

        // sweep offsets and delay settings
        for (int d = 0; d < 4; d++)
            for (int off = -5; off <= 5; off++) run_cmp(off, d);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule